// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block is the interrupt controller beside a small 8-bit CPU core. It collects fourteen maskable event lines and one non-maskable software-trap request. For each maskable line it keeps a pending flag and an enable bit. It also keeps one global enable, a trap pending flag that software cannot address, and a record that the trap is being serviced. At every instruction boundary that the CPU marks, the block decides whether to raise its interrupt request. When the CPU acknowledges, the block clears the global enable so that one maskable handler cannot be interrupted by another.

Inside the common handler, the CPU issues a vector-select strobe. The block then ranks the active sources and returns an even byte offset that replaces the low byte of the program counter. The trap returns 0xFE. Maskable input bit i returns 0xE2 + 2*i. When nothing is active, the block returns the default slot 0xE0. Two maskable positions are reserved and can never become pending. Return-from-interrupt sets the global enable again, and a dedicated command clears the trap flag.

Top module: `irq_vec_arbiter`

## Requirements
- R1: A maskable source is active when both its pending bit and its enable bit are 1. `irq_o` is updated only in a cycle where `boundary_i` is 1. There it becomes 1 when an active source exists, global enable is 1 and the trap flag is 0. At every other time it holds its value, except that `ack_i` clears it.
- R2: While the trap flag is set, maskable sources raise no request. The trap itself raises `irq_o` at a boundary whatever the global enable is, until an acknowledge marks it as in service.
- R3: `ack_i` clears the global enable on the next clock edge. `ack_i` wins over `reti_i` and over a software write in the same cycle.
- R4: `reti_i` sets the global enable to 1, so that an active source left over is requested at the next boundary.
- R5: The offset is 0xFE when the trap flag is set. Otherwise it is 0xE2 + 2*i for the highest-numbered active input bit i, so bit 12 gives 0xFA and bit 0 gives 0xE2. A higher bit number means a higher rank.
- R6: When no source is active, the offset is 0xE0. A source that is pending but not enabled does not count as active.
- R7: Arbitration uses the state present in the cycle where `vis_i` is 1. The offset appears on the next edge, with `vec_vld_o` high for one cycle. An event that arrives in that same cycle does not affect the result.
- R8: The trap flag is set by `trap_i`. Only `rpnd_i` or reset clears it. A write to the pending register leaves it unchanged.
- R9: Reset clears every pending bit, every enable bit, the global enable, the trap state, `irq_o` and `vec_vld_o`.
- R10: When `pnd_we_i` is 1, each 0 bit of `wdata_i` clears that pending bit and each 1 bit leaves it unchanged. A pulse on `evt_i` sets the bit. When a set and a clear meet in the same cycle, the set wins.
- R11: Input bits 7 and 13 are reserved. Their pending and enable bits always read 0, and the offsets 0xF0 and 0xFC are never produced.
- R12: `en_we_i` loads `wdata_i` into the enable bits. `gie_we_i` loads `gie_wdata_i` into the global enable. Both are readable on `en_o` and `gie_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 14 | Event pulses; each sets the pending bit at the same position |
| trap_i | input | 1 | Software-trap occurrence |
| pnd_we_i | input | 1 | Write strobe for the pending register (clear-only) |
| en_we_i | input | 1 | Write strobe for the enable register |
| wdata_i | input | 14 | Write data for the pending and enable registers |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| boundary_i | input | 1 | Start of an instruction; the request is sampled here |
| ack_i | input | 1 | Interrupt acknowledge |
| vis_i | input | 1 | Vector-select command |
| reti_i | input | 1 | Return from interrupt |
| rpnd_i | input | 1 | Clear the trap pending flag |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_off_o | output | 8 | Even low-byte vector offset |
| vec_vld_o | output | 1 | One-cycle pulse when `vec_off_o` is updated |
| gie_o | output | 1 | Global enable |
| pnd_o | output | 14 | Pending bits |
| en_o | output | 14 | Enable bits |

## Verification
The properties assume that the CPU never raises `ack_i` and `reti_i` in the same cycle, and that it acknowledges only after a request. They also assume that `rpnd_i` is issued only while the trap is in service. The stimulus drives each command strobe on its own, one per cycle, except where a requirement depends on two strobes meeting: the set-against-clear collision and the event arriving in the vector-select cycle. Vector-select commands go through a scoreboard queue, and every offset the block reports is compared with the one predicted from the requirement table.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  typedef enum logic [1:0] {
    GOP_HOLD  = 2'd0,
    GOP_CLR   = 2'd1,
    GOP_SET   = 2'd2,
    GOP_WRITE = 2'd3
  } gie_op_e;

  // offset of maskable position idx: one slot above the default slot
  function automatic logic [7:0] slot_offset(input logic [7:0] base, input int idx);
    logic [7:0] step;
    step = 8'((idx + 1) * 2);
    return base + step;
  endfunction

endpackage

// File: rtl/irqarb_rst_sync.sv
module irqarb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irqarb_src_bank.sv
module irqarb_src_bank #(
  parameter int              NSRC = 14,
  parameter logic [NSRC-1:0] RESV = 14'h2080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            pnd_we_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] pnd_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] act_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic pnd_q, pnd_d, en_q, en_d, keep;

    always_comb begin
      keep  = !(pnd_we_i && !wdata_i[g]);
      pnd_d = (evt_i[g] || (pnd_q && keep)) && !RESV[g];
      en_d  = (en_we_i ? wdata_i[g] : en_q) && !RESV[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pnd_q <= 1'b0;
        en_q  <= 1'b0;
      end else begin
        pnd_q <= pnd_d;
        en_q  <= en_d;
      end
    end

    assign pnd_o[g] = pnd_q;
    assign en_o[g]  = en_q;
    assign act_o[g] = pnd_q && en_q;

    if (!RESV[g]) begin : g_chk
      AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[g] |=> pnd_o[g]); // R10
      AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnd_o[g] && !evt_i[g]) |=> !pnd_o[g]); // R10
    end
  end

endmodule

// File: rtl/irqarb_prio_enc.sv
module irqarb_prio_enc #(
  parameter int         NSRC     = 14,
  parameter logic [7:0] VEC_BASE = 8'hE0
) (
  input  logic [NSRC-1:0] act_i,
  input  logic            trap_i,
  output logic [7:0]      off_o
);
  import irqarb_pkg::*;

  localparam logic [7:0] TRAP_OFF = slot_offset(VEC_BASE, NSRC);

  always_comb begin
    off_o = VEC_BASE;
    for (int i = 0; i < NSRC; i++) begin
      if (act_i[i]) off_o = slot_offset(VEC_BASE, i);
    end
    if (trap_i) off_o = TRAP_OFF;
  end

endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_act_i,
  input  logic [7:0] enc_off_i,
  input  logic       trap_i,
  input  logic       gie_we_i,
  input  logic       gie_wdata_i,
  input  logic       boundary_i,
  input  logic       ack_i,
  input  logic       vis_i,
  input  logic       reti_i,
  input  logic       rpnd_i,
  output logic       trap_pnd_o,
  output logic       irq_o,
  output logic [7:0] vec_off_o,
  output logic       vec_vld_o,
  output logic       gie_o
);
  import irqarb_pkg::*;

  logic       gie_q, gie_d;
  logic       trap_q, trap_d;
  logic       svc_q, svc_d;
  logic       irq_q, irq_d;
  logic [7:0] vec_q, vec_d;
  logic       vld_q, vld_d;
  logic       req;
  gie_op_e    gop;

  always_comb begin
    if (ack_i)         gop = GOP_CLR;
    else if (reti_i)   gop = GOP_SET;
    else if (gie_we_i) gop = GOP_WRITE;
    else               gop = GOP_HOLD;

    case (gop)
      GOP_CLR:   gie_d = 1'b0;
      GOP_SET:   gie_d = 1'b1;
      GOP_WRITE: gie_d = gie_wdata_i;
      default:   gie_d = gie_q;
    endcase

    trap_d = trap_i || (trap_q && !rpnd_i);
    svc_d  = !rpnd_i && (svc_q || (ack_i && trap_q));

    req = (trap_q && !svc_q) || (any_act_i && gie_q && !trap_q);

    if (ack_i)           irq_d = 1'b0;
    else if (boundary_i) irq_d = req;
    else                 irq_d = irq_q;

    vec_d = vis_i ? enc_off_i : vec_q;
    vld_d = vis_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      trap_q <= 1'b0;
      svc_q  <= 1'b0;
      irq_q  <= 1'b0;
      vec_q  <= 8'h00;
      vld_q  <= 1'b0;
    end else begin
      gie_q  <= gie_d;
      trap_q <= trap_d;
      svc_q  <= svc_d;
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      vld_q  <= vld_d;
    end
  end

  assign trap_pnd_o = trap_q;
  assign irq_o      = irq_q;
  assign vec_off_o  = vec_q;
  assign vec_vld_o  = vld_q;
  assign gie_o      = gie_q;

  AST_IRQ_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> !$rose(irq_o)); // R1
  AST_NO_MASKED_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && svc_q && !ack_i) |=> !irq_o); // R2
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !gie_o); // R3
  AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i) |=> gie_o); // R4
  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pnd_o && !rpnd_i) |=> trap_pnd_o); // R8
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> (vec_off_o[0] == 1'b0)); // R7

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
  parameter int              NSRC     = 14,
  parameter logic [NSRC-1:0] RESV     = 14'h2080,
  parameter logic [7:0]      VEC_BASE = 8'hE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            trap_i,
  input  logic            pnd_we_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            gie_we_i,
  input  logic            gie_wdata_i,
  input  logic            boundary_i,
  input  logic            ack_i,
  input  logic            vis_i,
  input  logic            reti_i,
  input  logic            rpnd_i,
  output logic            irq_o,
  output logic [7:0]      vec_off_o,
  output logic            vec_vld_o,
  output logic            gie_o,
  output logic [NSRC-1:0] pnd_o,
  output logic [NSRC-1:0] en_o
);
  import irqarb_pkg::*;

  logic            rst_n_s;
  logic [NSRC-1:0] act;
  logic [7:0]      enc_off;
  logic            trap_pnd;
  logic            resv_hit;

  irqarb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irqarb_src_bank #(.NSRC(NSRC), .RESV(RESV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .evt_i    (evt_i),
    .pnd_we_i (pnd_we_i),
    .en_we_i  (en_we_i),
    .wdata_i  (wdata_i),
    .pnd_o    (pnd_o),
    .en_o     (en_o),
    .act_o    (act)
  );

  irqarb_prio_enc #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_enc (
    .act_i  (act),
    .trap_i (trap_pnd),
    .off_o  (enc_off)
  );

  irqarb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .any_act_i   (|act),
    .enc_off_i   (enc_off),
    .trap_i      (trap_i),
    .gie_we_i    (gie_we_i),
    .gie_wdata_i (gie_wdata_i),
    .boundary_i  (boundary_i),
    .ack_i       (ack_i),
    .vis_i       (vis_i),
    .reti_i      (reti_i),
    .rpnd_i      (rpnd_i),
    .trap_pnd_o  (trap_pnd),
    .irq_o       (irq_o),
    .vec_off_o   (vec_off_o),
    .vec_vld_o   (vec_vld_o),
    .gie_o       (gie_o)
  );

  always_comb begin
    resv_hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (RESV[i] && vec_off_o == slot_offset(VEC_BASE, i)) resv_hit = 1'b1;
    end
  end

  AST_RESV_NEVER_VECTORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    vec_vld_o |-> !resv_hit); // R11
  AST_RESV_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pnd_o & RESV) == '0); // R11

endmodule

// File: tb/irq_vec_arbiter_test.sv
`timescale 1ns/1ps
module irq_vec_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] evt_i, wdata_i, pnd_o, en_o;
  logic        trap_i, pnd_we_i, en_we_i, gie_we_i, gie_wdata_i;
  logic        boundary_i, ack_i, vis_i, reti_i, rpnd_i;
  logic        irq_o, vec_vld_o, gie_o;
  logic [7:0]  vec_off_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { logic [7:0] off; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  irq_vec_arbiter uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .trap_i(trap_i),
    .pnd_we_i(pnd_we_i), .en_we_i(en_we_i), .wdata_i(wdata_i),
    .gie_we_i(gie_we_i), .gie_wdata_i(gie_wdata_i), .boundary_i(boundary_i),
    .ack_i(ack_i), .vis_i(vis_i), .reti_i(reti_i), .rpnd_i(rpnd_i),
    .irq_o(irq_o), .vec_off_o(vec_off_o), .vec_vld_o(vec_vld_o),
    .gie_o(gie_o), .pnd_o(pnd_o), .en_o(en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected offset for every reported vector
  always @(negedge clk) begin
    if (rst_n && vec_vld_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected vector actual=%0h expected=none", vec_off_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {24'h0, vec_off_o}, {24'h0, e.off});
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    evt_i = '0; trap_i = 0; pnd_we_i = 0; en_we_i = 0; wdata_i = '0;
    gie_we_i = 0; gie_wdata_i = 0; boundary_i = 0; ack_i = 0;
    vis_i = 0; reti_i = 0; rpnd_i = 0;
  endtask

  task automatic vis(input logic [7:0] exp, input string tag);
    exp_q.push_back('{off: exp, tag: tag});
    vis_i = 1; step(); idle();
  endtask

  task automatic wr_en(input logic [13:0] d);
    en_we_i = 1; wdata_i = d; step(); idle();
  endtask

  task automatic wr_pnd(input logic [13:0] d);
    pnd_we_i = 1; wdata_i = d; step(); idle();
  endtask

  task automatic wr_gie(input logic d);
    gie_we_i = 1; gie_wdata_i = d; step(); idle();
  endtask

  task automatic fire(input logic [13:0] e);
    evt_i = e; step(); idle();
  endtask

  task automatic boundary();
    boundary_i = 1; step(); idle();
  endtask

  task automatic ack();
    ack_i = 1; step(); idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();

    // R9 reset state
    chk("R9 pnd", {18'h0, pnd_o}, 0);
    chk("R9 en", {18'h0, en_o}, 0);
    chk("R9 gie", {31'h0, gie_o}, 0);
    chk("R9 irq", {31'h0, irq_o}, 0);
    chk("R9 vld", {31'h0, vec_vld_o}, 0);

    // R12 / R11 enable write, reserved bits stay 0
    wr_en(14'h3FFF);
    chk("R12 en readback", {18'h0, en_o}, 32'h1F7F);

    // R10 / R11 events, reserved positions ignored
    fire(14'h2088);
    chk("R11 reserved pend", {18'h0, pnd_o}, 32'h0008);

    // R1 request only with gie, and only at a boundary
    boundary();
    chk("R1 no irq gie0", {31'h0, irq_o}, 0);
    wr_gie(1);
    chk("R12 gie write", {31'h0, gie_o}, 1);
    chk("R1 no irq off boundary", {31'h0, irq_o}, 0);
    boundary();
    chk("R1 irq at boundary", {31'h0, irq_o}, 1);

    vis(8'hE8, "R5 bit3");

    // R3 acknowledge clears gie and the request
    ack();
    chk("R3 gie cleared", {31'h0, gie_o}, 0);
    chk("R3 irq cleared", {31'h0, irq_o}, 0);
    boundary();
    chk("R3 no nesting", {31'h0, irq_o}, 0);

    // R10 clear-only write and set-wins collision
    wr_pnd(~14'h0008);
    chk("R10 clear", {18'h0, pnd_o}, 0);
    pnd_we_i = 1; wdata_i = '0; evt_i = 14'h0020; step(); idle();
    chk("R10 set wins", {18'h0, pnd_o}, 32'h0020);

    // R6 pending without enable is not active
    wr_en(14'h0000);
    vis(8'hE0, "R6 default");

    // R5 ranking among several active sources
    wr_pnd(14'h0000);
    wr_en(14'h3FFF);
    fire(14'h1201);
    vis(8'hFA, "R5 bit12");
    wr_pnd(~14'h1000);
    // R7 event in the vector-select cycle is not seen
    vis_i = 1; evt_i = 14'h0800;
    exp_q.push_back('{off: 8'hF4, tag: "R7 sampled state"});
    step(); idle();
    vis(8'hF8, "R7 later event");

    // R4 return restores gie and re-requests
    reti_i = 1; step(); idle();
    chk("R4 gie set", {31'h0, gie_o}, 1);
    boundary();
    chk("R4 re-request", {31'h0, irq_o}, 1);
    ack();

    // R2 / R8 software trap
    trap_i = 1; step(); idle();
    boundary();
    chk("R2 trap irq gie0", {31'h0, irq_o}, 1);
    vis(8'hFE, "R5 trap");
    ack();
    chk("R2 trap ack", {31'h0, irq_o}, 0);
    wr_gie(1);
    boundary();
    chk("R2 masked blocked", {31'h0, irq_o}, 0);
    wr_pnd(14'h0000);
    vis(8'hFE, "R8 write keeps trap");
    fire(14'h0010);
    rpnd_i = 1; step(); idle();
    vis(8'hEA, "R8 cleared by command");
    boundary();
    chk("R2 maskable resumes", {31'h0, irq_o}, 1);

    repeat (3) step();
    chk("R7 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule